// File: doc/BRIEF.md
# Address-Decoded Two-Operand ALU Peripheral

This block is a 16-bit arithmetic and logic unit that sits on a simple processor bus as a memory-mapped slave. It occupies a 64-byte window. Software loads the two operands by writing to the window, then reads the result back from the same window. The processor has no opcode field. The operation is chosen by the address used for the read: the low five address bits name one of 32 functions.

Within those five bits, bit 4 picks the mode. A 1 selects arithmetic and a 0 selects bitwise logic. Bits 3..0 pick one of 16 operations in that mode. On a write, bit 5 of the address chooses the operand register, and the low five bits are ignored. The result is combinational from the two stored operands. The read port shows data only while the block is read inside its window. At all other times the read data is held at zero and the select flag is low, so it can be OR-combined with other slaves.

The block has no state machine. Its only state is the pair of operand registers. Each register has two conditions: it holds its value, or it loads on a write whose address selects it.

Top module: `mmio_alu`

## Requirements
- R1: After reset both operands read as zero. A read at offset 0x0A returns operand A and a read at offset 0x0B returns operand B.
- R2: A write inside the window with address bit 5 = 0 loads operand A from the write data on the next clock edge. With bit 5 = 1 it loads operand B. The other operand is unchanged, and address bits 4..0 have no effect on a write.
- R3: A write whose address lies outside the window, base 0xC000 through 0xC03F, changes neither operand.
- R4: While the read strobe is high and the address is inside the window, the select flag is 1 in the same cycle. The read data is the function named by address bits 4..0, and address bit 5 has no effect on a read.
- R5: When the read strobe is low or the address is outside the window, the select flag is 0 and the read data is 0x0000.
- R6: Arithmetic codes, with bit 4 = 1 and bits 3..0 as listed: 0 A, 1 A+1, 2 A+B, 3 A+B+1, 4 A−B−1, 5 A−B, 6 A−1, 7 A+A, 8 B, 9 B+1, A B−1, B B−A, C A+A+1, D −A, E B+B, F −B.
- R7: Logic codes, with bit 4 = 0 and bits 3..0 as listed: 0 ~A, 1 ~B, 2 A&B, 3 A|B, 4 A^B, 5 ~(A^B), 6 ~(A&B), 7 ~(A|B), 8 zero, 9 all ones, A A, B B, C A&~B, D ~A&B, E A|~B, F ~A|B.
- R8: Arithmetic results wrap modulo 2^16, and the carry out is discarded.
- R9: A read at offset 0x12 returns A+B.
- R10: When a read and a write to the window happen in the same cycle, the read returns a result built from the operands held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address shared by reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, zero when not selected |
| bus_rsel | output | 1 | High when this block drives the read data |

## Verification
The hardest case to reach is a read and a write in the same cycle. The bus has only one address, so that shared address must select both the operand being loaded and the function being read. The bench holds both strobes at an address that loads A and also reads A back. It samples once before the clock edge, expecting the old value, and once after it, expecting the new value. Operand values that carry across every bit, and values that borrow through zero, are used to exercise the modulo wrap.

// File: rtl/mmio_alu_pkg.sv
package mmio_alu_pkg;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        AR_A      = 4'h0, AR_AINC  = 4'h1, AR_ADD   = 4'h2, AR_ADDC  = 4'h3,
        AR_SUBB   = 4'h4, AR_SUB   = 4'h5, AR_ADEC  = 4'h6, AR_ADBL  = 4'h7,
        AR_B      = 4'h8, AR_BINC  = 4'h9, AR_BDEC  = 4'hA, AR_RSUB  = 4'hB,
        AR_ADBL1  = 4'hC, AR_NEGA  = 4'hD, AR_BDBL  = 4'hE, AR_NEGB  = 4'hF
    } arith_op_e;

    typedef enum logic [CODE_W-1:0] {
        LG_NOTA   = 4'h0, LG_NOTB  = 4'h1, LG_AND   = 4'h2, LG_OR    = 4'h3,
        LG_XOR    = 4'h4, LG_XNOR  = 4'h5, LG_NAND  = 4'h6, LG_NOR   = 4'h7,
        LG_ZERO   = 4'h8, LG_ONES  = 4'h9, LG_PASSA = 4'hA, LG_PASSB = 4'hB,
        LG_ANDNB  = 4'hC, LG_NAANDB = 4'hD, LG_ORNB = 4'hE, LG_NAORB = 4'hF
    } logic_op_e;

    typedef struct packed {
        logic                  arith;
        logic [CODE_W-1:0]     code;
    } alu_func_t;
endpackage

// File: rtl/mmio_alu_decode.sv
module mmio_alu_decode
    import mmio_alu_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          WIN_W     = 6,
    parameter logic [15:0] BASE_ADDR = 16'hC000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_window,
    output logic              sel_b,
    output alu_func_t         func
);
    localparam int TAG_W = ADDR_W - WIN_W;
    localparam logic [TAG_W-1:0] TAG = BASE_ADDR[ADDR_W-1:WIN_W];

    always_comb begin
        in_window  = (addr[ADDR_W-1:WIN_W] == TAG);
        sel_b      = addr[WIN_W-1];
        func.arith = addr[CODE_W];
        func.code  = addr[CODE_W-1:0];
    end
endmodule

// File: rtl/mmio_alu_opregs.sv
module mmio_alu_opregs #(
    parameter int DATA_W = 16,
    parameter int N_OPS  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(N_OPS)-1:0]  wr_sel,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [DATA_W-1:0]         op_q [N_OPS]
);
    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        logic load;
        always_comb load = wr_en && (wr_sel == g[$clog2(N_OPS)-1:0]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    op_q[g] <= '0;
            else if (load) op_q[g] <= wr_data;
        end

        assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == g[$clog2(N_OPS)-1:0]) |=> (op_q[g] == $past(wr_data)));
        assert_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == g[$clog2(N_OPS)-1:0]) |=> $stable(op_q[g]));
    end
endmodule

// File: rtl/mmio_alu_arith.sv
module mmio_alu_arith
    import mmio_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  arith_op_e          op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic [DATA_W-1:0]  y
);
    localparam logic [DATA_W-1:0] ZERO = '0;
    localparam logic [DATA_W-1:0] ONES = '1;

    logic [DATA_W-1:0] x_in, y_in;
    logic              cin;
    logic [DATA_W:0]   sum;

    always_comb begin
        unique case (op)
            AR_A:     begin x_in = a;  y_in = ZERO; cin = 1'b0; end
            AR_AINC:  begin x_in = a;  y_in = ZERO; cin = 1'b1; end
            AR_ADD:   begin x_in = a;  y_in = b;    cin = 1'b0; end
            AR_ADDC:  begin x_in = a;  y_in = b;    cin = 1'b1; end
            AR_SUBB:  begin x_in = a;  y_in = ~b;   cin = 1'b0; end
            AR_SUB:   begin x_in = a;  y_in = ~b;   cin = 1'b1; end
            AR_ADEC:  begin x_in = a;  y_in = ONES; cin = 1'b0; end
            AR_ADBL:  begin x_in = a;  y_in = a;    cin = 1'b0; end
            AR_B:     begin x_in = b;  y_in = ZERO; cin = 1'b0; end
            AR_BINC:  begin x_in = b;  y_in = ZERO; cin = 1'b1; end
            AR_BDEC:  begin x_in = b;  y_in = ONES; cin = 1'b0; end
            AR_RSUB:  begin x_in = b;  y_in = ~a;   cin = 1'b1; end
            AR_ADBL1: begin x_in = a;  y_in = a;    cin = 1'b1; end
            AR_NEGA:  begin x_in = ~a; y_in = ZERO; cin = 1'b1; end
            AR_BDBL:  begin x_in = b;  y_in = b;    cin = 1'b0; end
            AR_NEGB:  begin x_in = ~b; y_in = ZERO; cin = 1'b1; end
            default:  begin x_in = a;  y_in = ZERO; cin = 1'b0; end
        endcase
        sum = {1'b0, x_in} + {1'b0, y_in} + {{DATA_W{1'b0}}, cin};
        y   = sum[DATA_W-1:0];
    end
endmodule

// File: rtl/mmio_alu_logic.sv
module mmio_alu_logic
    import mmio_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic_op_e          op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic [DATA_W-1:0]  y
);
    always_comb begin
        unique case (op)
            LG_NOTA:   y = ~a;
            LG_NOTB:   y = ~b;
            LG_AND:    y = a & b;
            LG_OR:     y = a | b;
            LG_XOR:    y = a ^ b;
            LG_XNOR:   y = ~(a ^ b);
            LG_NAND:   y = ~(a & b);
            LG_NOR:    y = ~(a | b);
            LG_ZERO:   y = '0;
            LG_ONES:   y = '1;
            LG_PASSA:  y = a;
            LG_PASSB:  y = b;
            LG_ANDNB:  y = a & ~b;
            LG_NAANDB: y = ~a & b;
            LG_ORNB:   y = a | ~b;
            LG_NAORB:  y = ~a | b;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/mmio_alu.sv
module mmio_alu
    import mmio_alu_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 16,
    parameter int          WIN_W     = 6,
    parameter logic [15:0] BASE_ADDR = 16'hC000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rsel
);
    localparam int N_OPS = 2;
    localparam logic [4:0] ADD_OFS = 5'h12;

    logic              in_window, sel_b;
    alu_func_t         func;
    logic [DATA_W-1:0] op_q [N_OPS];
    logic [DATA_W-1:0] arith_y, logic_y, result;

    mmio_alu_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(bus_addr), .in_window(in_window), .sel_b(sel_b), .func(func)
    );

    mmio_alu_opregs #(.DATA_W(DATA_W), .N_OPS(N_OPS)) u_ops (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr && in_window), .wr_sel(sel_b),
        .wr_data(bus_wdata), .op_q(op_q)
    );

    mmio_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .op(arith_op_e'(func.code)), .a(op_q[0]), .b(op_q[1]), .y(arith_y)
    );

    mmio_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .op(logic_op_e'(func.code)), .a(op_q[0]), .b(op_q[1]), .y(logic_y)
    );

    always_comb begin
        result    = func.arith ? arith_y : logic_y;
        bus_rsel  = bus_rd && in_window;
        bus_rdata = bus_rsel ? result : '0;
    end

    assert_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[ADDR_W-1:WIN_W] == BASE_ADDR[ADDR_W-1:WIN_W]) |-> bus_rsel);
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rsel |-> (bus_rdata == '0));
    assert_add_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rsel && bus_addr[4:0] == ADD_OFS) |-> (bus_rdata == DATA_W'(op_q[0] + op_q[1])));
    assert_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_window |=> ($stable(op_q[0]) && $stable(op_q[1])));
endmodule

// File: tb/tb_mmio_alu.sv
module tb_mmio_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        bus_rsel;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mmio_alu dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rsel(bus_rsel)
    );

    // {A, B, read offset, expected}
    localparam int NV = 17;
    localparam logic [63:0] VEC [NV] = '{
        {16'h1234, 16'h0101, 16'h0012, 16'h1335},   // R9 add
        {16'hFFFF, 16'h0001, 16'h0012, 16'h0000},   // R8 wrap
        {16'h0005, 16'h0003, 16'h0015, 16'h0002},   // R6 sub
        {16'h0003, 16'h0005, 16'h0015, 16'hFFFE},   // R8 borrow
        {16'h8000, 16'h0000, 16'h0017, 16'h0000},   // R8 A+A
        {16'h0000, 16'h0000, 16'h0016, 16'hFFFF},   // R6 A-1
        {16'h1234, 16'h0101, 16'h0014, 16'h1132},   // R6 A-B-1
        {16'h1234, 16'h0101, 16'h0013, 16'h1336},   // R6 A+B+1
        {16'h0001, 16'h0002, 16'h001B, 16'h0001},   // R6 B-A
        {16'h0001, 16'h0000, 16'h001D, 16'hFFFF},   // R6 -A
        {16'h00FF, 16'h0F0F, 16'h0002, 16'h000F},   // R7 and
        {16'h00FF, 16'h0F0F, 16'h0004, 16'h0FF0},   // R7 xor
        {16'h00FF, 16'h0F0F, 16'h0007, 16'hF000},   // R7 nor
        {16'h00FF, 16'h0F0F, 16'h000C, 16'h00F0},   // R7 A&~B
        {16'h00FF, 16'h0F0F, 16'h0009, 16'hFFFF},   // R7 ones
        {16'h00FF, 16'h0F0F, 16'h0008, 16'h0000},   // R7 zero
        {16'h00FF, 16'h0F0F, 16'h0000, 16'hFF00}    // R7 not A
    };

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_read(input string req, input logic [15:0] a, input logic [15:0] exp,
                              input logic exp_sel);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        check(req, bus_rdata, exp);
        check(req, {15'd0, bus_rsel}, {15'd0, exp_sel});
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        check_read("R1 A", 16'hC00A, 16'h0000, 1'b1);
        check_read("R1 B", 16'hC00B, 16'h0000, 1'b1);

        // R5: idle and outside window
        #2;
        check("R5 idle", {bus_rsel, bus_rdata[14:0]}, 16'h0000);
        check_read("R5 outside", 16'hC040, 16'h0000, 1'b0);

        // vector table: A written with low bits set (R2), B at bit5
        for (int i = 0; i < NV; i++) begin
            do_write(16'hC01F, VEC[i][63:48]);
            do_write(16'hC020, VEC[i][47:32]);
            check_read("R6/R7/R8/R9 vec", 16'hC000 | VEC[i][31:16], VEC[i][15:0], 1'b1);
        end

        // R2: writing A leaves B alone
        do_write(16'hC020, 16'h5A5A);
        do_write(16'hC005, 16'h1111);
        check_read("R2 B kept", 16'hC00B, 16'h5A5A, 1'b1);
        check_read("R2 A loaded", 16'hC00A, 16'h1111, 1'b1);

        // R3: writes outside the window ignored
        do_write(16'hC040, 16'hAAAA);
        do_write(16'hBFFF, 16'hBBBB);
        do_write(16'h4020, 16'hCCCC);
        check_read("R3 A", 16'hC00A, 16'h1111, 1'b1);
        check_read("R3 B", 16'hC00B, 16'h5A5A, 1'b1);

        // R4: address bit 5 ignored on read (0x32 acts as 0x12)
        check_read("R4 bit5", 16'hC032, 16'h6B6B, 1'b1);

        // R10: simultaneous write and read at the same address
        @(negedge clk);
        bus_addr = 16'hC00A; bus_wdata = 16'h0020; bus_wr = 1'b1; bus_rd = 1'b1;
        #2;
        check("R10 before edge", bus_rdata, 16'h1111);
        @(negedge clk);
        bus_wr = 1'b0;
        #2;
        check("R10 after edge", bus_rdata, 16'h0020);
        bus_rd = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule